// File: doc/BRIEF.md
# Expansion Bus Width Converter

This block sits between a 32-bit processor port and an external expansion bus of selectable width. For each processor request it works out the width of the target bus, then runs one expansion cycle or a short ascending series of narrower cycles. It gathers the read data into the proper byte lanes and gives the processor a one-cycle completion pulse.

The bus width comes from a 2-bit programmable field. The meaning of that field is rotated by a boot strap, which is captured while power-on reset is held. One encoding selects a card-interface mode. In that mode, processor address bits 27 and 26 choose between byte and halfword targets and between memory and I/O space. One case, halfword I/O, never splits a word. In that case processor address bit 25 is moved onto expansion address bit 1, so single 16-bit registers can be reached one at a time.

Top module: `expWidthConv`

## Requirements
- R1: `strapPin` is sampled on every clock while `porN` is low, and the captured value is held after `porN` rises. A system reset through `rstN` alone does not change it.
- R2: Any reset clears the width field to 00. With the strap at 0, field 00 selects a 32-bit bus, 01 a 16-bit bus, 10 an 8-bit bus and 11 card mode. `expWidth` reports the bus width as 0 for 8-bit, 1 for 16-bit and 2 for 32-bit.
- R3: With the strap at 1, field 00 selects an 8-bit bus, 01 card mode, 10 a 32-bit bus and 11 a 16-bit bus.
- R4: In card mode, `expCard` is high and `{cpuAddr[27],cpuAddr[26]}` selects the target. 00 is 8-bit attribute memory, 01 is 16-bit common memory, 10 is 8-bit I/O and 11 is 16-bit I/O.
- R5: A word access (`cpuSize` 2, or the value 3) ignores `cpuAddr[1:0]`.
  - On an 8-bit bus it becomes four cycles at byte offsets 0, 1, 2 and 3.
  - On a 16-bit bus it becomes two cycles at offsets 0 and 2.
  - On a 32-bit bus it is one cycle.
  - `expSize` gives the size of each cycle as 0 for a byte, 1 for a halfword and 2 for a word.
  - Write data for a cycle sits in the low lanes of `expWdata`, and the unused lanes are zero.
- R6: On reads, each cycle takes the low `expSize` bytes of `expRdata` and places them in the `cpuRdata` lane given by the low two bits of that cycle's unmodified byte address. Lanes that were not read are zero.
- R7: A byte access (`cpuSize` 0) at its own address, or a halfword access (`cpuSize` 1) with bit 0 cleared, is one cycle when it is no wider than the bus. A halfword on an 8-bit bus is two byte cycles.
- R8: In 16-bit I/O mode a word access is one halfword cycle, and `cpuRdata[31:16]` reads as zero. For every access in this mode, `expAddr[1]` equals `cpuAddr[25]`.
- R9: `expAddr[25]` is always 0.
- R10: `expStrobe` stays high with a stable `expAddr` until `expReady` is seen high on a clock edge. Only then does the next cycle start.
- R11: `cpuDone` is high for exactly one clock, in the cycle after the edge that sampled `expReady` for the last cycle. `cpuRdata` holds the assembled result in that cycle.
- R12: `busy` is high from the cycle after a request is accepted through the `cpuDone` cycle. A `cpuReq` pulse while `busy` is high is dropped and starts no expansion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low; strap sampled while low |
| rstN | input | 1 | System reset, active low |
| strapPin | input | 1 | Boot width strap level |
| cfgWrEn | input | 1 | Write strobe for the width field |
| cfgWidth | input | 2 | New width field value |
| cpuReq | input | 1 | One-cycle request pulse, taken only while not busy |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cpuAddr | input | 32 | Processor byte address |
| cpuWdata | input | 32 | Write data, lanes by address |
| cpuRdata | output | 32 | Assembled read data |
| cpuDone | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| expAddr | output | 32 | Expansion byte address |
| expWdata | output | 32 | Expansion write data, low lanes |
| expRdata | input | 32 | Expansion read data, low lanes |
| expStrobe | output | 1 | Expansion cycle active |
| expWrite | output | 1 | Expansion cycle direction |
| expReady | input | 1 | Cycle complete from the target |
| expWidth | output | 2 | Resolved bus width code |
| expSize | output | 2 | Size code of the current cycle |
| expCard | output | 1 | Card-interface mode active |

## Verification
The bench goes after these corner cases:
- **Rotated strap table.** A design that ignored the strap would give 32-bit for field 00 after a strap-high power-on.
- **The strap surviving a system reset.** A design that re-sampled the pin on `rstN` would flip widths after a plain reset.
- **The halfword I/O word.** A design that split it, or left bit 1 alone, would show two cycles or the wrong address. A design that kept the upper half would return stale or garbage data there.
- **Read lane masking.** The responder drives all four lanes with distinct values, so a design that did not mask unread lanes would corrupt `cpuRdata`.
- **Random wait states.** These expose a sequencer that advances without `expReady`.
- **Requests while busy.** A design that accepted a request in mid-sequence would show extra expansion cycles.

// File: rtl/expConvPkg.sv
package expConvPkg;

  // resolved bus width code, also the log2 of its byte count
  typedef enum logic [1:0] {
    BW8  = 2'd0,
    BW16 = 2'd1,
    BW32 = 2'd2
  } busWidthE;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       load;     // latch a new processor request
    logic       capture;  // current expansion cycle completes this edge
    logic [1:0] partIdx;  // index of the current part
    logic [1:0] partLog;  // log2 bytes per part
    logic       io16;     // halfword I/O remap active
  } convStrobeT;

endpackage

// File: rtl/expConvCtrl.sv
module expConvCtrl
  import expConvPkg::*;
(
  input  logic       clk,
  input  logic       resetN,
  input  logic       porN,
  input  logic       strapPin,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgWidth,
  input  logic       cpuReq,
  input  logic       cpuWrite,
  input  logic [1:0] cpuSize,
  input  logic [1:0] cpuSelBits,
  input  logic       expReady,
  output logic       busy,
  output logic       cpuDone,
  output logic       expStrobe,
  output logic       expWrite,
  output logic [1:0] expWidth,
  output logic [1:0] expSize,
  output logic       expCard,
  output convStrobeT strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} stateE;

  stateE      state;
  logic       bootReg;
  logic [1:0] fieldReg;
  logic [1:0] idxReg;
  logic [1:0] lastReg;
  logic [1:0] partLogReg;
  busWidthE   busWReg;
  logic       io16Reg;
  logic       cardReg;
  logic       writeReg;

  // strap capture, only during power-on reset
  always_ff @(posedge clk) begin
    if (!porN) bootReg <= strapPin;
  end

  always_ff @(posedge clk) begin
    if (!resetN)      fieldReg <= 2'b00;
    else if (cfgWrEn) fieldReg <= cfgWidth;
  end

  // decode of the incoming request
  logic [1:0] effField;
  logic       cardSel;
  logic       reqIo16;
  busWidthE   busWNext;
  logic [1:0] accLog;
  logic [1:0] partLogNext;
  logic [1:0] nPartLog;
  logic [1:0] lastNext;

  always_comb begin
    // the strap rotates the table by two entries
    effField = fieldReg ^ {bootReg, 1'b0};
    cardSel  = (effField == 2'b11);
    reqIo16  = cardSel && (cpuSelBits == 2'b11);
    unique case (effField)
      2'b00:   busWNext = BW32;
      2'b01:   busWNext = BW16;
      2'b10:   busWNext = BW8;
      default: busWNext = cpuSelBits[0] ? BW16 : BW8;
    endcase
    accLog      = (cpuSize == 2'd3) ? 2'd2 : cpuSize;
    partLogNext = (accLog < 2'(busWNext)) ? accLog : 2'(busWNext);
    if (reqIo16 && accLog == 2'd2) nPartLog = 2'd0;
    else                           nPartLog = accLog - partLogNext;
    unique case (nPartLog)
      2'd0:    lastNext = 2'd0;
      2'd1:    lastNext = 2'd1;
      default: lastNext = 2'd3;
    endcase
  end

  logic accept;
  logic partDone;
  assign accept   = (state == ST_IDLE) && cpuReq;
  assign partDone = (state == ST_RUN) && expReady;

  always_ff @(posedge clk) begin
    if (!resetN) begin
      state      <= ST_IDLE;
      idxReg     <= 2'd0;
      lastReg    <= 2'd0;
      partLogReg <= 2'd0;
      busWReg    <= BW32;
      io16Reg    <= 1'b0;
      cardReg    <= 1'b0;
      writeReg   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state      <= ST_RUN;
          idxReg     <= 2'd0;
          lastReg    <= lastNext;
          partLogReg <= partLogNext;
          busWReg    <= busWNext;
          io16Reg    <= reqIo16;
          cardReg    <= cardSel;
          writeReg   <= cpuWrite;
        end
        ST_RUN: if (expReady) begin
          if (idxReg == lastReg) state <= ST_DONE;
          else                   idxReg <= idxReg + 2'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign cpuDone   = (state == ST_DONE);
  assign expStrobe = (state == ST_RUN);
  assign expWrite  = writeReg;
  assign expWidth  = busWReg;
  assign expSize   = partLogReg;
  assign expCard   = cardReg;

  always_comb begin
    strb.load    = accept;
    strb.capture = partDone;
    strb.partIdx = idxReg;
    strb.partLog = partLogReg;
    strb.io16    = io16Reg;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!resetN)
    cpuDone |=> !cpuDone);                                          // R11
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!resetN)
    $rose(cpuDone) |-> $past(expStrobe && expReady));               // R11
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!resetN)
    expStrobe |-> busy);                                            // R12
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!resetN)
    busy |=> $stable(busWReg) && $stable(partLogReg));              // R12
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!resetN)
    expStrobe |-> idxReg <= lastReg);                               // R5

endmodule

// File: rtl/expConvDatapath.sv
module expConvDatapath
  import expConvPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REMAP_BIT = 25,
  parameter int ZERO_BIT  = 25
) (
  input  logic              clk,
  input  logic              resetN,
  input  convStrobeT        strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  input  logic [31:0]       expRdata,
  output logic [ADDR_W-1:0] expAddr,
  output logic [31:0]       expWdata,
  output logic [31:0]       cpuRdata
);

  logic [ADDR_W-1:0] baseReg;
  logic [31:0]       wdReg;
  logic [31:0]       accReg;
  logic              remapReg;

  logic [ADDR_W-1:0] alignedAddr;
  always_comb begin
    alignedAddr = cpuAddr;
    if (cpuSize[1])      alignedAddr[1:0] = 2'b00;
    else if (cpuSize[0]) alignedAddr[0]   = 1'b0;
  end

  logic [ADDR_W-1:0] lineAddr;
  logic [1:0]        lane;
  logic [31:0]       laneMask;
  logic [31:0]       placed;

  always_comb begin
    lineAddr = baseReg + (ADDR_W'(strb.partIdx) << strb.partLog);
    lane     = lineAddr[1:0];
    unique case (strb.partLog)
      2'd0:    laneMask = 32'h0000_00FF;
      2'd1:    laneMask = 32'h0000_FFFF;
      default: laneMask = 32'hFFFF_FFFF;
    endcase
    expWdata = (wdReg >> {lane, 3'b000}) & laneMask;
    placed   = (expRdata & laneMask) << {lane, 3'b000};
    expAddr  = lineAddr;
    if (strb.io16) expAddr[1] = remapReg;
    expAddr[ZERO_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!resetN) begin
      baseReg  <= '0;
      wdReg    <= '0;
      accReg   <= '0;
      remapReg <= 1'b0;
    end else if (strb.load) begin
      baseReg  <= alignedAddr;
      wdReg    <= cpuWdata;
      accReg   <= '0;
      remapReg <= cpuAddr[REMAP_BIT];
    end else if (strb.capture) begin
      accReg <= accReg | placed;
    end
  end

  assign cpuRdata = accReg;

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!resetN)
    strb.load |=> cpuRdata == 32'd0);                                       // R6
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!resetN)
    (strb.capture && strb.partLog == 2'd0) |=>
      $countones(cpuRdata ^ $past(cpuRdata)) <= 8);                         // R6

endmodule

// File: rtl/expWidthConv.sv
module expWidthConv
  import expConvPkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        rstN,
  input  logic        strapPin,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgWidth,
  input  logic        cpuReq,
  input  logic        cpuWrite,
  input  logic [1:0]  cpuSize,
  input  logic [31:0] cpuAddr,
  input  logic [31:0] cpuWdata,
  output logic [31:0] cpuRdata,
  output logic        cpuDone,
  output logic        busy,
  output logic [31:0] expAddr,
  output logic [31:0] expWdata,
  input  logic [31:0] expRdata,
  output logic        expStrobe,
  output logic        expWrite,
  input  logic        expReady,
  output logic [1:0]  expWidth,
  output logic [1:0]  expSize,
  output logic        expCard
);

  localparam int ADDR_W  = 32;
  localparam int SEL_LO  = 26;
  localparam int REMAP_B = 25;

  logic       resetN;
  convStrobeT strb;

  assign resetN = rstN && porN;

  expConvCtrl uCtrl (
    .clk        (clk),
    .resetN     (resetN),
    .porN       (porN),
    .strapPin   (strapPin),
    .cfgWrEn    (cfgWrEn),
    .cfgWidth   (cfgWidth),
    .cpuReq     (cpuReq),
    .cpuWrite   (cpuWrite),
    .cpuSize    (cpuSize),
    .cpuSelBits (cpuAddr[SEL_LO+1:SEL_LO]),
    .expReady   (expReady),
    .busy       (busy),
    .cpuDone    (cpuDone),
    .expStrobe  (expStrobe),
    .expWrite   (expWrite),
    .expWidth   (expWidth),
    .expSize    (expSize),
    .expCard    (expCard),
    .strb       (strb)
  );

  expConvDatapath #(
    .ADDR_W    (ADDR_W),
    .REMAP_BIT (REMAP_B),
    .ZERO_BIT  (REMAP_B)
  ) uData (
    .clk      (clk),
    .resetN   (resetN),
    .strb     (strb),
    .cpuAddr  (cpuAddr),
    .cpuSize  (cpuSize),
    .cpuWdata (cpuWdata),
    .expRdata (expRdata),
    .expAddr  (expAddr),
    .expWdata (expWdata),
    .cpuRdata (cpuRdata)
  );

  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!resetN)
    (expStrobe && !expReady) |=> expStrobe && $stable(expAddr));             // R10
  AST_ADDR25_LOW: assert property (@(posedge clk) disable iff (!resetN)
    expStrobe |-> !expAddr[25]);                                             // R9
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!resetN)
    (expStrobe && $past(expStrobe) && $past(expReady)) |->
      expAddr != $past(expAddr));                                            // R5

endmodule

// File: tb/sim_expWidthConv.sv
module sim_expWidthConv;

  logic        clk = 1'b0;
  logic        porN, rstN, strapPin, cfgWrEn;
  logic [1:0]  cfgWidth;
  logic        cpuReq, cpuWrite;
  logic [1:0]  cpuSize;
  logic [31:0] cpuAddr, cpuWdata, cpuRdata;
  logic        cpuDone, busy;
  logic [31:0] expAddr, expWdata, expRdata;
  logic        expStrobe, expWrite, expReady;
  logic [1:0]  expWidth, expSize;
  logic        expCard;

  always #4 clk = ~clk;  // 125 MHz

  expWidthConv u0 (.*);

  int cyc = 0;
  always @(posedge clk) cyc++;

  int errors = 0;
  int checks = 0;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
  endfunction

  // expansion target model with random wait states
  logic [31:0] logAddr[8];
  logic [31:0] logWd[8];
  logic [1:0]  logSize[8];
  logic [1:0]  logWidth[8];
  logic        logCard[8];
  logic        logWr[8];
  int          nLog = 0;
  int          lastReadyCyc = 0;
  int          waitCnt = 0;

  always @(negedge clk) begin
    if (expReady) begin
      expReady = 1'b0;
      waitCnt  = int'($urandom % 3);
    end else if (expStrobe) begin
      if (waitCnt == 0) begin
        if (nLog < 8) begin
          logAddr[nLog]  = expAddr;
          logWd[nLog]    = expWdata;
          logSize[nLog]  = expSize;
          logWidth[nLog] = expWidth;
          logCard[nLog]  = expCard;
          logWr[nLog]    = expWrite;
        end
        nLog++;
        expRdata = {pat(expAddr + 32'd3), pat(expAddr + 32'd2),
                    pat(expAddr + 32'd1), pat(expAddr)};
        expReady = 1'b1;
        lastReadyCyc = cyc;
      end else begin
        waitCnt--;
      end
    end
  end

  logic       bootModel;
  logic [1:0] cfgModel;

  // bus width log2 from the tables in R2, R3, R4
  function automatic int modelBus(input logic boot, input logic [1:0] fld,
                                  input logic [1:0] sel, output logic card,
                                  output logic io);
    int bw;
    card = 1'b0;
    io   = 1'b0;
    case ({boot, fld})
      3'b000: bw = 2;
      3'b001: bw = 1;
      3'b010: bw = 0;
      3'b100: bw = 0;
      3'b110: bw = 2;
      3'b111: bw = 1;
      default: begin
        card = 1'b1;
        bw   = (sel == 2'b01 || sel == 2'b11) ? 1 : 0;
        io   = (sel == 2'b11);
      end
    endcase
    return bw;
  endfunction

  task automatic powerOn(input logic strap);
    porN = 1'b0; rstN = 1'b1; strapPin = strap;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    bootModel = strap;
    cfgModel  = 2'b00;
    @(negedge clk);
  endtask

  task automatic sysReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cfgModel = 2'b00;
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [1:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWidth = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    cfgModel = v;
  endtask

  task automatic doAccess(input logic wr, input logic [1:0] size,
                          input logic [31:0] addr, input logic [31:0] wd);
    logic card, io;
    int busLog, accLog, pLog, nParts, t;
    logic [31:0] base, la, ea, mask, expR;
    string rq, wq;
    busLog = modelBus(bootModel, cfgModel, addr[27:26], card, io);
    accLog = (size == 2'd3) ? 2 : int'(size);
    pLog   = (accLog < busLog) ? accLog : busLog;
    nParts = (io && accLog == 2) ? 1 : (1 << (accLog - pLog));
    base   = addr;
    if (accLog == 2) base[1:0] = 2'b00;
    else if (accLog == 1) base[0] = 1'b0;
    mask = (pLog == 0) ? 32'hFF : (pLog == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    rq = io ? "R8" : (accLog < 2) ? "R7" : "R5";
    wq = card ? "R4" : bootModel ? "R3" : "R2";
    @(negedge clk);
    nLog = 0;
    cpuReq = 1'b1; cpuWrite = wr; cpuSize = size; cpuAddr = addr; cpuWdata = wd;
    @(negedge clk);
    cpuReq = 1'b0;
    t = 0;
    while (!cpuDone && t < 200) begin
      @(negedge clk);
      t++;
    end
    check("R11", {31'd0, cpuDone}, 32'd1, "done seen");
    check("R11", cyc, lastReadyCyc + 1, "done timing");
    check(rq, nLog, nParts, "part count");
    expR = 32'd0;
    for (int k = 0; k < nParts && k < nLog && k < 8; k++) begin
      la = base + (32'(k) << pLog);
      ea = la;
      if (io) ea[1] = addr[25];
      ea[25] = 1'b0;
      check(rq, logAddr[k], ea, "part address");
      check("R9", {31'd0, logAddr[k][25]}, 32'd0, "address bit 25");
      check("R5", {30'd0, logSize[k]}, 32'(pLog), "part size");
      check(wq, {30'd0, logWidth[k]}, 32'(busLog), "bus width");
      check("R4", {31'd0, logCard[k]}, {31'd0, card}, "card flag");
      check("R5", {31'd0, logWr[k]}, {31'd0, wr}, "direction");
      if (wr) check("R5", logWd[k], (wd >> (8 * la[1:0])) & mask, "write data");
      for (int j = 0; j < (1 << pLog); j++)
        expR[8 * (la[1:0] + j) +: 8] = pat(ea + 32'(j));
    end
    if (!wr) check(io ? "R8" : "R6", cpuRdata, expR, "read data");
    @(negedge clk);
    check("R11", {31'd0, cpuDone}, 32'd0, "done single pulse");
    check("R12", {31'd0, busy}, 32'd0, "busy cleared");
  endtask

  task automatic randomAccesses(input int n);
    for (int i = 0; i < n; i++)
      doAccess($urandom % 2, 2'($urandom % 4), $urandom, $urandom);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    porN = 1'b0; rstN = 1'b0; strapPin = 1'b0; cfgWrEn = 1'b0; cfgWidth = 2'b00;
    cpuReq = 1'b0; cpuWrite = 1'b0; cpuSize = 2'd0; cpuAddr = '0; cpuWdata = '0;
    expRdata = '0; expReady = 1'b0;
    bootModel = 1'b0; cfgModel = 2'b00;

    // strap low
    powerOn(1'b0);
    rstN = 1'b1;
    check("R2", {31'd0, busy}, 32'd0, "reset busy");
    check("R2", {31'd0, expStrobe}, 32'd0, "reset strobe");
    check("R11", {31'd0, cpuDone}, 32'd0, "reset done");
    doAccess(1'b1, 2'd2, 32'h1000_0004, 32'hA1B2_C3D4);   // R2 field 00 -> 32-bit
    for (int f = 0; f < 4; f++) begin
      writeCfg(2'(f));
      randomAccesses(30);
    end

    // strap high
    powerOn(1'b1);
    for (int f = 0; f < 4; f++) begin
      writeCfg(2'(f));
      randomAccesses(30);
    end

    // R8: halfword I/O word read, card mode under strap high is field 01
    writeCfg(2'b01);
    doAccess(1'b0, 2'd2, 32'h0E00_0010, 32'd0);
    doAccess(1'b1, 2'd2, 32'h0E00_0020, 32'h1234_5678);
    doAccess(1'b0, 2'd1, 32'h0C00_0102, 32'd0);
    // R7: halfword onto an 8-bit bus (card attribute space)
    doAccess(1'b1, 2'd1, 32'h0000_0006, 32'hBEEF_CAFE);

    // R1: pin changes, system reset only; strap stays 1, field back to 00 -> 8-bit
    strapPin = 1'b0;
    sysReset();
    doAccess(1'b0, 2'd2, 32'h0000_0040, 32'd0);
    check("R1", {30'd0, logWidth[0]}, 32'd0, "strap kept over system reset");

    // R12: request pulse during a split sequence is dropped
    @(negedge clk);
    nLog = 0;
    cpuReq = 1'b1; cpuWrite = 1'b1; cpuSize = 2'd2; cpuAddr = 32'h0000_0100; cpuWdata = 32'h0102_0304;
    @(negedge clk);
    cpuReq = 1'b0;
    @(negedge clk);
    check("R12", {31'd0, busy}, 32'd1, "busy during sequence");
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuSize = 2'd0; cpuAddr = 32'h0000_0200;
    @(negedge clk);
    cpuReq = 1'b0;
    for (int t = 0; t < 100 && !cpuDone; t++) @(negedge clk);
    repeat (8) @(negedge clk);
    check("R12", nLog, 4, "cycles after dropped request");
    check("R12", {31'd0, expStrobe}, 32'd0, "no extra cycle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule